// File: doc/BRIEF.md
# Modular Exponentiation Engine with Word-Addressed Operand Banks

The engine computes S = M^E mod N for operands up to a parameterised maximum width (256 bits by default). The modulus width and the exponent width are chosen at run time. Software loads four operand banks (modulus, message, exponent, result) over a simple chip-select bus that moves one 32-bit word per access.

Two handshakes drive the engine. A rising edge on `init` starts a one-time precomputation for the loaded modulus. It derives the Montgomery constant R² mod N with R = 2^w by repeated doubling with conditional subtraction, and raises `ready` when it finishes. A rising edge on `next` runs one exponentiation, and `valid` rises once the result bank holds the answer.

Several messages may be processed under one modulus. A new modulus is loaded by rewriting its bank and repeating `init`. A mode input selects either a faster square-and-multiply that skips the multiply on zero exponent bits, or a constant-time variant that always multiplies and keeps the product only when the bit is one. All products come from one bit-serial Montgomery multiplier that handles one multiplier bit per cycle.

Top module: `mx_modexp_engine`

## Requirements
- R1: A clock edge with `bus_cs`=1 and `bus_we`=1 stores `bus_wdata` into the word selected by `bus_addr`. The upper two address bits are the bank (00 modulus, 01 message, 10 exponent, 11 result) and the lower bits are the word offset, where offset 0 is the least significant 32 bits of the operand.
- R2: While `bus_cs`=1 and `bus_we`=0, `bus_rdata` shows the addressed word combinationally in the same cycle. Otherwise `bus_rdata` is zero.
- R3: Bus writes to the result bank have no effect. Only the engine writes it, and it is zero after reset.
- R4: After reset `ready` and `valid` are 0. A rising edge of `init` while idle drops `ready` for the whole precomputation and raises it when R² mod N is stored for the latched modulus width.
- R5: A rising edge of `next` while idle and ready clears `valid`, computes M^E mod N from the message, exponent and modulus banks, writes the result bank and then sets `valid`. Only exponent bits below `exp_width` are used. This holds for N odd, 1 < N < 2^`mod_width`, and M < N.
- R6: With `public_mode`=0 the number of cycles per exponent bit is the same for every bit. The total operation time therefore does not depend on the exponent value.
- R7: With `public_mode`=1 zero exponent bits skip the multiply, so an exponent with fewer one bits finishes in fewer cycles.
- R8: Many exponentiations may run under one precomputation, and a new modulus takes effect after its bank is reloaded and `init` is repeated.
- R9: Rising edges of `init` or `next` while an operation is running are ignored. A level held high never retriggers. `next` is ignored until a precomputation has completed.
- R10: An exponent of zero yields the result 1.
- R11: Every Montgomery product leaves the multiplier below N, and its accumulator stays below 2N while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Rising edge starts modulus precomputation |
| ready | output | 1 | Precomputation complete |
| next | input | 1 | Rising edge starts an exponentiation |
| valid | output | 1 | Result bank holds M^E mod N |
| mod_width | input | $clog2(MAXW+1) | Modulus width in bits, latched at init |
| exp_width | input | $clog2(MAXW+1) | Exponent width in bits, used at next |
| public_mode | input | 1 | 1 = data-dependent fast path, 0 = constant time |
| bus_cs | input | 1 | Chip select |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 2+offset bits | Bank code over word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |

## Verification
The bench builds the engine with a maximum width of 64 bits. This gives two words per bank, a one-bit offset field and 7-bit width inputs. Because each product then takes only a few cycles at narrow run-time widths, the bench can sweep every message under a 6-bit modulus with mixed modes, and sweep a spread of exponents under an 8-bit modulus, comparing each result with modular arithmetic done directly in the bench. Full 64-bit operations with a modulus change exercise multiword transfer, while cycle counts of chosen exponents show constant time in one mode and the data-dependent shortcut in the other.

// File: rtl/mx_pkg.sv
`timescale 1ns/1ps
package mx_pkg;
  localparam logic [1:0] BANK_MOD = 2'b00;
  localparam logic [1:0] BANK_MSG = 2'b01;
  localparam logic [1:0] BANK_EXP = 2'b10;
  localparam logic [1:0] BANK_RES = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_MBAR, ST_ONE, ST_SQR, ST_MUL, ST_OUT
  } mx_state_e;

  typedef enum logic [1:0] {MM_IDLE, MM_RUN, MM_FIX} mm_phase_e;
endpackage

// File: rtl/mx_bank_regs.sv
`timescale 1ns/1ps
module mx_bank_regs #(
  parameter int MAXW  = 256,
  parameter int WORDW = 32,
  parameter int NW    = (MAXW + WORDW - 1) / WORDW,
  parameter int OFFB  = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [OFFB+1:0]   addr,
  input  logic [WORDW-1:0]  wdata,
  output logic [WORDW-1:0]  rdata,
  input  logic              res_we,
  input  logic [MAXW-1:0]   res_val,
  output logic [MAXW-1:0]   mod_o,
  output logic [MAXW-1:0]   msg_o,
  output logic [MAXW-1:0]   exp_o
);
  import mx_pkg::*;
  localparam int FLATW = NW * WORDW;

  logic [WORDW-1:0] mem_q [4][NW];
  logic [FLATW-1:0] flat [4];
  logic [FLATW-1:0] res_pad;
  logic [1:0]       sel_bank;
  logic [OFFB-1:0]  sel_off;
  logic             wr_evt, rd_evt;

  assign sel_bank = addr[OFFB+1:OFFB];
  assign sel_off  = addr[OFFB-1:0];
  assign wr_evt   = cs && we;
  assign rd_evt   = cs && !we;
  assign res_pad  = FLATW'(res_val);

  for (genvar b = 0; b < 4; b++) begin : g_bank
    for (genvar w = 0; w < NW; w++) begin : g_word
      if (b == 3) begin : g_res
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)      mem_q[b][w] <= '0;
          else if (res_we) mem_q[b][w] <= res_pad[w*WORDW +: WORDW];
      end else begin : g_sw
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) mem_q[b][w] <= '0;
          else if (wr_evt && sel_bank == 2'(b) && sel_off == OFFB'(w))
            mem_q[b][w] <= wdata;
      end
      assign flat[b][w*WORDW +: WORDW] = mem_q[b][w];
    end
  end

  assign mod_o = flat[BANK_MOD][MAXW-1:0];
  assign msg_o = flat[BANK_MSG][MAXW-1:0];
  assign exp_o = flat[BANK_EXP][MAXW-1:0];

  always_comb begin
    rdata = '0;
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < NW; w++)
        if (rd_evt && sel_bank == 2'(b) && sel_off == OFFB'(w))
          rdata = mem_q[b][w];
  end

  // R3: software cannot alter the result bank
  p_res_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && sel_bank == BANK_RES && !res_we) |=> $stable(flat[BANK_RES]))
    else $error("result bank changed by bus write");

  // R2: nothing appears on the read bus without a read access
  p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |-> rdata == '0)
    else $error("read data without read access");
endmodule

// File: rtl/mx_mont_mul.sv
`timescale 1ns/1ps
module mx_mont_mul #(
  parameter int MAXW = 256,
  parameter int CW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MAXW-1:0] x,
  input  logic [MAXW-1:0] y,
  input  logic [MAXW-1:0] n,
  input  logic [CW-1:0]   nbits,
  output logic            done,
  output logic [MAXW-1:0] prod
);
  import mx_pkg::*;
  localparam int AW = MAXW + 2;

  // one radix-2 Montgomery step: (acc + b*x + q*n) / 2
  function automatic logic [AW-1:0] mont_step(input logic [AW-1:0] acc,
      input logic [MAXW-1:0] xv, input logic b, input logic [MAXW-1:0] nv);
    logic [AW-1:0] t;
    t = acc + (b ? {2'b00, xv} : '0);
    if (t[0]) t = t + {2'b00, nv};
    return t >> 1;
  endfunction

  function automatic logic [AW-1:0] cond_sub(input logic [AW-1:0] a,
      input logic [MAXW-1:0] nv);
    return (a >= {2'b00, nv}) ? a - {2'b00, nv} : a;
  endfunction

  mm_phase_e       phase_q;
  logic [AW-1:0]   acc_q;
  logic [MAXW-1:0] y_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;
  logic [MAXW-1:0] prod_q;
  logic [AW-1:0]   fixed;

  assign fixed = cond_sub(acc_q, n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_q <= MM_IDLE; acc_q <= '0; y_q <= '0; cnt_q <= '0;
      done_q <= 1'b0; prod_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        MM_IDLE: if (start) begin
          acc_q <= '0; y_q <= y; cnt_q <= nbits; phase_q <= MM_RUN;
        end
        MM_RUN: begin
          acc_q <= mont_step(acc_q, x, y_q[0], n);
          y_q   <= y_q >> 1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) phase_q <= MM_FIX;
        end
        MM_FIX: begin
          prod_q  <= fixed[MAXW-1:0];
          done_q  <= 1'b1;
          phase_q <= MM_IDLE;
        end
        default: phase_q <= MM_IDLE;
      endcase
    end

  assign done = done_q;
  assign prod = prod_q;

  // R11: reduced product and bounded accumulator
  p_prod_below_n_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> prod_q < n)
    else $error("product not reduced");
  p_acc_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == MM_RUN |-> acc_q < {1'b0, n, 1'b0})
    else $error("accumulator out of range");
endmodule

// File: rtl/mx_exp_seq.sv
`timescale 1ns/1ps
module mx_exp_seq #(
  parameter int MAXW = 256,
  parameter int CW   = $clog2(MAXW + 1),
  parameter int IW   = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            next,
  input  logic            pub_mode,
  input  logic [CW-1:0]   mod_width,
  input  logic [CW-1:0]   exp_width,
  input  logic [MAXW-1:0] n_i,
  input  logic [MAXW-1:0] m_i,
  input  logic [MAXW-1:0] e_i,
  input  logic            mm_done,
  input  logic [MAXW-1:0] mm_prod,
  output logic            mm_start,
  output logic [MAXW-1:0] mm_x,
  output logic [MAXW-1:0] mm_y,
  output logic [CW-1:0]   mm_nbits,
  output logic            res_we,
  output logic [MAXW-1:0] res_val,
  output logic            ready,
  output logic            valid
);
  import mx_pkg::*;
  localparam logic [MAXW-1:0] ONE = MAXW'(1);
  localparam int PCW = CW + 3;

  // 2r mod n for r < n
  function automatic logic [MAXW-1:0] dbl_sub(input logic [MAXW-1:0] r,
      input logic [MAXW-1:0] nv);
    logic [MAXW:0] t;
    t = {r, 1'b0};
    if (t >= {1'b0, nv}) t = t - {1'b0, nv};
    return t[MAXW-1:0];
  endfunction

  mx_state_e       state_q;
  logic            issued_q, init_q, next_q, pub_q, ready_q, valid_q;
  logic [MAXW-1:0] r2_q, mbar_q, acc_q;
  logic [CW-1:0]   w_q;
  logic [CW:0]     cnt_q;
  logic [IW-1:0]   idx_q;

  logic idle, init_rise, next_rise, accept_init, accept_next;
  logic mult_state, mm_fin, cur_bit, last_bit, sqr_launch;

  assign idle        = state_q == ST_IDLE;
  assign init_rise   = init && !init_q;
  assign next_rise   = next && !next_q;
  assign accept_init = idle && init_rise;
  assign accept_next = idle && next_rise && !init_rise && ready_q;
  assign mult_state  = state_q inside {ST_MBAR, ST_ONE, ST_SQR, ST_MUL, ST_OUT};
  assign mm_start    = mult_state && !issued_q;
  assign mm_fin      = mult_state && issued_q && mm_done;
  assign cur_bit     = e_i[idx_q];
  assign last_bit    = idx_q == '0;
  assign sqr_launch  = state_q == ST_SQR && mm_start;
  assign mm_nbits    = w_q;
  assign res_we      = state_q == ST_OUT && mm_fin;
  assign res_val     = mm_prod;
  assign ready       = ready_q;
  assign valid       = valid_q;

  always_comb begin
    mm_x = acc_q;
    mm_y = acc_q;
    case (state_q)
      ST_MBAR: begin mm_x = m_i;    mm_y = r2_q;  end
      ST_ONE:  begin mm_x = r2_q;   mm_y = ONE;   end
      ST_MUL:  begin mm_x = mbar_q; mm_y = acc_q; end
      ST_OUT:  begin mm_x = acc_q;  mm_y = ONE;   end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= ST_IDLE; issued_q <= 1'b0; init_q <= 1'b0; next_q <= 1'b0;
      pub_q <= 1'b0; ready_q <= 1'b0; valid_q <= 1'b0;
      r2_q <= '0; mbar_q <= '0; acc_q <= '0; w_q <= '0; cnt_q <= '0; idx_q <= '0;
    end else begin
      init_q <= init;
      next_q <= next;
      if (mm_start) issued_q <= 1'b1;
      if (mm_fin)   issued_q <= 1'b0;
      case (state_q)
        ST_IDLE:
          if (accept_init) begin
            w_q     <= mod_width;
            r2_q    <= ONE;
            cnt_q   <= {mod_width, 1'b0};
            ready_q <= 1'b0;
            state_q <= ST_PRE;
          end else if (accept_next) begin
            pub_q   <= pub_mode;
            idx_q   <= IW'(exp_width - CW'(1));
            valid_q <= 1'b0;
            state_q <= ST_MBAR;
          end
        ST_PRE: begin
          r2_q  <= dbl_sub(r2_q, n_i);
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == (CW+1)'(1)) begin
            ready_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_MBAR: if (mm_fin) begin mbar_q <= mm_prod; state_q <= ST_ONE; end
        ST_ONE:  if (mm_fin) begin acc_q  <= mm_prod; state_q <= ST_SQR; end
        ST_SQR: if (mm_fin) begin
          acc_q <= mm_prod;
          if (cur_bit || !pub_q) state_q <= ST_MUL;
          else if (last_bit)     state_q <= ST_OUT;
          else begin idx_q <= idx_q - 1'b1; state_q <= ST_SQR; end
        end
        ST_MUL: if (mm_fin) begin
          if (cur_bit) acc_q <= mm_prod;
          if (last_bit) state_q <= ST_OUT;
          else begin idx_q <= idx_q - 1'b1; state_q <= ST_SQR; end
        end
        ST_OUT: if (mm_fin) begin valid_q <= 1'b1; state_q <= ST_IDLE; end
        default: state_q <= ST_IDLE;
      endcase
    end

  // per-bit period observer for the constant-time property
  logic [PCW-1:0] per_cyc_q, per_ref_q;
  logic           seen_q, ref_v_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_cyc_q <= '0; per_ref_q <= '0; seen_q <= 1'b0; ref_v_q <= 1'b0;
    end else if (accept_next) begin
      per_cyc_q <= '0; seen_q <= 1'b0; ref_v_q <= 1'b0;
    end else if (sqr_launch) begin
      per_cyc_q <= '0;
      seen_q    <= 1'b1;
      if (seen_q && !ref_v_q) begin per_ref_q <= per_cyc_q; ref_v_q <= 1'b1; end
    end else begin
      per_cyc_q <= per_cyc_q + 1'b1;
    end

  p_const_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sqr_launch && seen_q && ref_v_q && !pub_q) |-> per_cyc_q == per_ref_q)
    else $error("exponent bit period varies in constant-time mode");
  p_ready_low_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PRE |-> !ready_q)
    else $error("ready high during precompute");
  p_valid_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_next |=> !valid_q)
    else $error("valid not cleared on start");
  p_next_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && next_rise) |=> state_q != ST_MBAR)
    else $error("next restarted a busy engine");
  p_init_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && init_rise) |=> $stable(w_q))
    else $error("init changed width while busy");
endmodule

// File: rtl/mx_modexp_engine.sv
`timescale 1ns/1ps
module mx_modexp_engine #(
  parameter int MAXW  = 256,
  localparam int WORDW = 32,
  localparam int NW    = (MAXW + WORDW - 1) / WORDW,
  localparam int OFFB  = (NW > 1) ? $clog2(NW) : 1,
  localparam int CW    = $clog2(MAXW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  output logic              ready,
  input  logic              next,
  output logic              valid,
  input  logic [CW-1:0]     mod_width,
  input  logic [CW-1:0]     exp_width,
  input  logic              public_mode,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [OFFB+1:0]   bus_addr,
  input  logic [WORDW-1:0]  bus_wdata,
  output logic [WORDW-1:0]  bus_rdata
);
  logic [MAXW-1:0] mod_v, msg_v, exp_v, res_v, mm_x, mm_y, mm_prod;
  logic            res_we, mm_start, mm_done;
  logic [CW-1:0]   mm_nbits;

  mx_bank_regs #(.MAXW(MAXW), .WORDW(WORDW), .NW(NW), .OFFB(OFFB)) u_banks (
    .clk(clk), .rst_n(rst_n), .cs(bus_cs), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .res_we(res_we), .res_val(res_v),
    .mod_o(mod_v), .msg_o(msg_v), .exp_o(exp_v)
  );

  mx_exp_seq #(.MAXW(MAXW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .init(init), .next(next), .pub_mode(public_mode),
    .mod_width(mod_width), .exp_width(exp_width), .n_i(mod_v), .m_i(msg_v),
    .e_i(exp_v), .mm_done(mm_done), .mm_prod(mm_prod), .mm_start(mm_start),
    .mm_x(mm_x), .mm_y(mm_y), .mm_nbits(mm_nbits), .res_we(res_we),
    .res_val(res_v), .ready(ready), .valid(valid)
  );

  mx_mont_mul #(.MAXW(MAXW), .CW(CW)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mm_start), .x(mm_x), .y(mm_y), .n(mod_v),
    .nbits(mm_nbits), .done(mm_done), .prod(mm_prod)
  );
endmodule

// File: tb/mx_modexp_engine_test.sv
`timescale 1ns/1ps
module mx_modexp_engine_test;
  localparam int MAXW = 64;
  localparam int CW   = 7;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n, init, next, public_mode, bus_cs, bus_we;
  logic ready, valid;
  logic [CW-1:0] mod_width, exp_width;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, failures = 0, cycle = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cycle++;

  mx_modexp_engine #(.MAXW(MAXW)) uut (
    .clk(clk), .rst_n(rst_n), .init(init), .ready(ready), .next(next),
    .valid(valid), .mod_width(mod_width), .exp_width(exp_width),
    .public_mode(public_mode), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial begin
    wait (cycle > LIMIT);
    failures++;
    $display("FAIL watchdog expired act=%0d exp<%0d", cycle, LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mulmod(input logic [63:0] a, b, n);
    logic [127:0] p;
    p = {64'd0, a} * {64'd0, b};
    return 64'(p % {64'd0, n});
  endfunction

  function automatic logic [63:0] ref_pow(input logic [63:0] m, e, n,
                                          input int ew);
    logic [63:0] r;
    r = 64'd1 % n;
    for (int i = ew - 1; i >= 0; i--) begin
      r = mulmod(r, r, n);
      if (e[i]) r = mulmod(r, m, n);
    end
    return r;
  endfunction

  task automatic bus_wr(input logic [1:0] b, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_addr = {b, 1'(off)}; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] b, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_addr = {b, 1'(off)};
    #1 d = bus_rdata;
    bus_cs = 0;
  endtask

  task automatic load(input logic [1:0] b, input logic [63:0] v);
    for (int i = 0; i < 2; i++) bus_wr(b, i, v[32*i +: 32]);
  endtask

  task automatic read_res(output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_rd(2'b11, 0, lo);
    bus_rd(2'b11, 1, hi);
    v = {hi, lo};
  endtask

  task automatic do_init(input logic [63:0] n, input int w);
    load(2'b00, n);
    @(negedge clk);
    mod_width = CW'(w); init = 1;
    @(negedge clk);
    chk(!ready, "R4 ready low in precompute", 64'(ready), 64'd0);
    while (!ready) @(negedge clk);
    chk(ready, "R4 ready after precompute", 64'(ready), 64'd1);
    init = 0;
  endtask

  task automatic run_op(input logic [63:0] m, e, input int ew, input bit pub,
                        output logic [63:0] r, output int cyc);
    load(2'b01, m);
    load(2'b10, e);
    @(negedge clk);
    exp_width = CW'(ew); public_mode = pub; next = 1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!valid);
    next = 0;
    read_res(r);
  endtask

  logic [63:0] r, exp_r;
  logic [31:0] d;
  int c0, c1, c2, cb;

  initial begin
    rst_n = 0; init = 0; next = 0; public_mode = 0; bus_cs = 0; bus_we = 0;
    bus_addr = '0; bus_wdata = '0; mod_width = '0; exp_width = '0;
    repeat (3) @(negedge clk);
    chk(!ready && !valid, "R4 reset state", {ready, valid}, 64'd0);
    chk(bus_rdata == 0, "R2 idle read bus", 64'(bus_rdata), 64'd0);
    rst_n = 1;

    // R1/R2: word access, offset 0 = low word
    bus_wr(2'b01, 0, 32'h1122_3344);
    bus_wr(2'b01, 1, 32'hAABB_CCDD);
    bus_rd(2'b01, 0, d); chk(d == 32'h1122_3344, "R1 word0", 64'(d), 64'h11223344);
    bus_rd(2'b01, 1, d); chk(d == 32'hAABB_CCDD, "R2 word1", 64'(d), 64'hAABBCCDD);
    // R3: result bank not writable from the bus
    bus_wr(2'b11, 0, 32'hDEAD_BEEF);
    bus_rd(2'b11, 0, d); chk(d == 0, "R3 result write ignored", 64'(d), 64'd0);
    // R9: next before precompute is ignored
    @(negedge clk); next = 1; repeat (30) @(negedge clk);
    chk(!valid, "R9 next before init", 64'(valid), 64'd0);
    next = 0;

    // exhaustive messages under a 6-bit modulus, both modes
    do_init(64'd61, 6);
    for (int m = 0; m < 61; m++) begin
      logic [63:0] e;
      e = 64'((m * 37 + 11) % 64);
      run_op(64'(m), e, 6, m[0], r, c0);
      exp_r = ref_pow(64'(m), e, 64'd61, 6);
      chk(r == exp_r, "R5 sweep n=61", r, exp_r);
    end

    // exponent sweep under an 8-bit modulus, same precompute (R8)
    do_init(64'd251, 8);
    for (int e = 0; e < 256; e += 5) begin
      run_op(64'd123, 64'(e), 8, e[1], r, c0);
      exp_r = ref_pow(64'd123, 64'(e), 64'd251, 8);
      chk(r == exp_r, e == 0 ? "R10 zero exponent" : "R8 repeated ops", r, exp_r);
    end

    // R5: exponent bits at and above exp_width ignored
    run_op(64'd77, 64'hF3, 4, 1'b0, r, c0);
    exp_r = ref_pow(64'd77, 64'd3, 64'd251, 4);
    chk(r == exp_r, "R5 high exponent bits ignored", r, exp_r);

    // R6: constant time in private mode
    run_op(64'd200, 64'h00, 8, 1'b0, r, c0);
    run_op(64'd200, 64'hFF, 8, 1'b0, r, c1);
    run_op(64'd200, 64'h5A, 8, 1'b0, r, c2);
    chk(c0 == c1, "R6 cycles e=00 vs FF", 64'(c0), 64'(c1));
    chk(c2 == c1, "R6 cycles e=5A vs FF", 64'(c2), 64'(c1));
    cb = c1;
    // R7: public mode skips multiplies on zero bits
    run_op(64'd200, 64'h01, 8, 1'b1, r, c0);
    run_op(64'd200, 64'hFF, 8, 1'b1, r, c1);
    chk(c0 < c1, "R7 sparse exponent faster", 64'(c0), 64'(c1));
    chk(c1 <= cb, "R7 public not slower", 64'(c1), 64'(cb));

    // R9: second next edge mid-run ignored, held level does not retrigger
    load(2'b01, 64'd99); load(2'b10, 64'hC3);
    @(negedge clk); exp_width = 8; public_mode = 0; next = 1;
    c0 = 0;
    repeat (10) begin @(negedge clk); c0++; end
    next = 0; @(negedge clk); c0++; next = 1;
    do begin @(negedge clk); c0++; end while (!valid);
    chk(c0 == cb, "R9 mid-run edge ignored", 64'(c0), 64'(cb));
    repeat (40) @(negedge clk);
    chk(valid, "R9 held next no restart", 64'(valid), 64'd1);
    next = 0;
    read_res(r);
    exp_r = ref_pow(64'd99, 64'hC3, 64'd251, 8);
    chk(r == exp_r, "R9 result intact", r, exp_r);

    // R8: full-width operands and a modulus change
    do_init(64'hE3A1_5C27_9B4D_0F61, 64);
    run_op(64'h0123_4567_89AB_CDEF, 64'hA5C3_0F1E_7788_9ABD, 64, 1'b0, r, c0);
    exp_r = ref_pow(64'h0123_4567_89AB_CDEF, 64'hA5C3_0F1E_7788_9ABD,
                    64'hE3A1_5C27_9B4D_0F61, 64);
    chk(r == exp_r, "R8 64-bit modulus 1", r, exp_r);
    do_init(64'h9F0E_7D6C_5B4A_3921, 64);
    run_op(64'h7654_3210_FEDC_BA98, 64'h0000_0001_0001_0003, 64, 1'b1, r, c0);
    exp_r = ref_pow(64'h7654_3210_FEDC_BA98, 64'h0000_0001_0001_0003,
                    64'h9F0E_7D6C_5B4A_3921, 64);
    chk(r == exp_r, "R8 64-bit modulus 2", r, exp_r);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule